// File: doc/BRIEF.md
# Preemption-Gated Exception Priority Arbiter

This block is the decision core of a small interrupt controller for a microcontroller-class CPU. It keeps a 2-bit priority level for each of 26 external interrupt lines and for three configurable system exceptions: supervisor call, deferred service and timer tick. It also holds a pending flag for every interrupt source. From the exception number the CPU is currently running and the global mask bit, it works out the execution priority. It then selects the one pending exception that may preempt that priority.

The selected exception is presented on `take_valid` / `take_exc`. When the CPU pulses `take_ack` while the offer is valid, the pending flag of that exception, and only that one, is cleared. Because a candidate must be strictly better than the running priority, an interrupt source that stays asserted cannot re-enter its own handler. Priorities are written and read through a plain 32-bit configuration port.

Exception numbers used throughout: 0 = thread mode, 2 = non-maskable interrupt (NMI), 3 = hard fault, 11 = supervisor call, 14 = deferred service, 15 = timer tick, 16+n = external IRQ n.

Top module: `prio_preempt_arb`

## Requirements
- R1: After reset every priority level is 0, every configuration word reads 0, no exception is pending and `take_valid` is low.
- R2: IRQ n is a candidate only while its pending flag is set and `irq_enable[n]` is high, and it is offered as exception number 16+n.
- R3: Configuration word k (k = 0..6) holds the levels of IRQs 4k..4k+3, with IRQ 4k+b at bits 8b+7:8b+6. Bytes for IRQs above 25 are dropped, and all other bits read as 0. Unmapped word indices read as 0.
- R4: Word 8 holds the supervisor-call level in bits 31:30. All other bits of that word are dropped on write and read as 0.
- R5: Word 9 holds the deferred-service level in bits 23:22 and the timer-tick level in bits 31:30. All other bits are dropped on write and read as 0.
- R6: In thread mode (`active_exc` = 0) the execution priority is worse than every level, so any candidate is offered.
- R7: A candidate is offered only if its level is numerically strictly lower than the execution priority, which is the level of `active_exc`. A candidate of equal or worse level is not offered, so an exception is never offered while it is itself the active one.
- R8: Among candidates with the same level, the lowest exception number is offered.
- R9: While `mask_all` is high, an execution priority worse than level 0 is raised to level 0. No configurable exception is then offered, but the NMI still is.
- R10: The NMI ranks above hard fault, and hard fault ranks above level 0. While hard fault is active, only the NMI can be offered.
- R11: A `take_ack` while `take_valid` is high clears only the offered exception's pending flag. A set request arriving in the same cycle wins over the clear.
- R12: `wake` is high exactly when `take_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_pend_set | input | 26 | Per-IRQ pending set request (level or pulse) |
| irq_enable | input | 26 | Per-IRQ enable |
| nmi_req | input | 1 | Sets the NMI pending flag |
| svc_req | input | 1 | Sets the supervisor-call pending flag |
| defer_req | input | 1 | Sets the deferred-service pending flag |
| tick_req | input | 1 | Sets the timer-tick pending flag |
| active_exc | input | 6 | Exception number currently executing |
| mask_all | input | 1 | Global interrupt mask |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational on `cfg_addr`) |
| take_valid | output | 1 | An exception may preempt now |
| take_exc | output | 6 | Number of the offered exception |
| take_ack | input | 1 | CPU accepts the offered exception |
| wake | output | 1 | Wake request for a sleeping core |

## Verification
The arbiter is tried with a single enabled IRQ in thread mode, and with the same IRQ disabled. This separates the enable gating from the pending logic. Pairs of candidates at equal level, both IRQ-versus-IRQ and system-versus-IRQ, expose any wrong scan order. Re-leveling one of them then shows that the level, rather than the number, decides when levels differ. A held IRQ running as the active exception, together with a second IRQ at equal and then better level, separates strict from non-strict comparison. Mask, hard-fault-active and set-during-acknowledge patterns cover the priority boost, the fixed ranks and the clear/set ordering.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  localparam int EXC_W  = 6;
  localparam int LVL_W  = 2;
  localparam int RANK_W = 3;

  typedef logic [RANK_W-1:0] rank_t;
  typedef logic [EXC_W-1:0]  exc_t;

  // Smaller rank wins. Levels 0..3 map onto ranks 3..6.
  localparam rank_t RANK_RSVD   = 3'd0;
  localparam rank_t RANK_NMI    = 3'd1;
  localparam rank_t RANK_HF     = 3'd2;
  localparam rank_t RANK_LVL0   = 3'd3;
  localparam rank_t RANK_THREAD = 3'd7;

  localparam exc_t EXC_THREAD = 6'd0;
  localparam exc_t EXC_NMI    = 6'd2;
  localparam exc_t EXC_HF     = 6'd3;
  localparam exc_t EXC_SVC    = 6'd11;
  localparam exc_t EXC_DEFER  = 6'd14;
  localparam exc_t EXC_TICK   = 6'd15;
  localparam int   IRQ_BASE   = 16;

  localparam int SYS2_WORD = 8;
  localparam int SYS3_WORD = 9;

  typedef struct packed {
    logic [LVL_W-1:0] svc;
    logic [LVL_W-1:0] defer;
    logic [LVL_W-1:0] tick;
  } sys_lvl_t;

  function automatic rank_t lvl_rank(input logic [LVL_W-1:0] lvl);
    return RANK_LVL0 + rank_t'(lvl);
  endfunction
endpackage

// File: rtl/ppa_prio_regs.sv
module ppa_prio_regs
  import ppa_pkg::*;
#(
  parameter int NUM_IRQ = 26,
  parameter int ADDR_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   wdata,
  output logic [NUM_IRQ-1:0][LVL_W-1:0] irq_lvl,
  output sys_lvl_t                      sys_lvl,
  output logic [31:0]                   rdata
);
  localparam int BYTES_PER_WORD = 4;

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
    localparam int WORD = gi / BYTES_PER_WORD;
    localparam int LSB  = 8 * (gi % BYTES_PER_WORD) + 6;
    logic             wr_en;
    logic [LVL_W-1:0] lvl_d, lvl_q;

    always_comb begin
      wr_en = we && (addr == ADDR_W'(WORD));
      lvl_d = wdata[LSB +: LVL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lvl_q <= '0;
      else if (wr_en) lvl_q <= lvl_d;
    end

    assign irq_lvl[gi] = lvl_q;
  end

  logic     sys2_en, sys3_en;
  sys_lvl_t sys_d, sys_q;

  always_comb begin
    sys2_en = we && (addr == ADDR_W'(SYS2_WORD));
    sys3_en = we && (addr == ADDR_W'(SYS3_WORD));
    sys_d   = sys_q;
    if (sys2_en) sys_d.svc = wdata[31:30];
    if (sys3_en) begin
      sys_d.defer = wdata[23:22];
      sys_d.tick  = wdata[31:30];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sys_q <= '0;
    else if (sys2_en || sys3_en) sys_q <= sys_d;
  end

  assign sys_lvl = sys_q;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (addr == ADDR_W'(i / BYTES_PER_WORD))
        rdata[8 * (i % BYTES_PER_WORD) + 6 +: LVL_W] = irq_lvl[i];
    end
    if (addr == ADDR_W'(SYS2_WORD)) rdata[31:30] = sys_q.svc;
    if (addr == ADDR_W'(SYS3_WORD)) begin
      rdata[31:30] = sys_q.tick;
      rdata[23:22] = sys_q.defer;
    end
  end

  // R4: a write to the supervisor-call word lands its top two bits
  p_svc_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(SYS2_WORD)) |=> (sys_lvl.svc == $past(wdata[31:30])));

  // R5: a write elsewhere leaves the system levels alone
  p_sys_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (addr == ADDR_W'(SYS2_WORD) || addr == ADDR_W'(SYS3_WORD))) |=> $stable(sys_lvl));
endmodule

// File: rtl/ppa_pending.sv
module ppa_pending
  import ppa_pkg::*;
#(
  parameter int NUM_IRQ = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_set,
  input  logic               nmi_set,
  input  logic               svc_set,
  input  logic               defer_set,
  input  logic               tick_set,
  input  logic               clr_en,
  input  exc_t               clr_exc,
  output logic [NUM_IRQ-1:0] irq_pend,
  output logic               nmi_pend,
  output logic               svc_pend,
  output logic               defer_pend,
  output logic               tick_pend
);
  logic [NUM_IRQ-1:0] irq_clr, irq_d, irq_q;
  logic               nmi_d, svc_d, defer_d, tick_d;
  logic               nmi_q, svc_q, defer_q, tick_q;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++)
      irq_clr[i] = clr_en && (clr_exc == EXC_W'(IRQ_BASE + i));
    // a set in the same cycle overrides the clear
    irq_d   = (irq_q & ~irq_clr) | irq_set;
    nmi_d   = (nmi_q   && !(clr_en && clr_exc == EXC_NMI))   || nmi_set;
    svc_d   = (svc_q   && !(clr_en && clr_exc == EXC_SVC))   || svc_set;
    defer_d = (defer_q && !(clr_en && clr_exc == EXC_DEFER)) || defer_set;
    tick_d  = (tick_q  && !(clr_en && clr_exc == EXC_TICK))  || tick_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= '0;
      nmi_q   <= 1'b0;
      svc_q   <= 1'b0;
      defer_q <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      irq_q   <= irq_d;
      nmi_q   <= nmi_d;
      svc_q   <= svc_d;
      defer_q <= defer_d;
      tick_q  <= tick_d;
    end
  end

  assign irq_pend   = irq_q;
  assign nmi_pend   = nmi_q;
  assign svc_pend   = svc_q;
  assign defer_pend = defer_q;
  assign tick_pend  = tick_q;

  // R11: acknowledging the supervisor call drops its flag when no new request arrives
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_exc == EXC_SVC && !svc_set) |=> !svc_pend);

  // R11: a request always leaves the flag set, even against a clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_set |=> nmi_pend);
endmodule

// File: rtl/ppa_select.sv
module ppa_select
  import ppa_pkg::*;
#(
  parameter int NUM_IRQ = 26
) (
  input  exc_t                          active_exc,
  input  logic                          mask_all,
  input  logic [NUM_IRQ-1:0]            irq_pend,
  input  logic [NUM_IRQ-1:0]            irq_enable,
  input  logic                          nmi_pend,
  input  logic                          svc_pend,
  input  logic                          defer_pend,
  input  logic                          tick_pend,
  input  logic [NUM_IRQ-1:0][LVL_W-1:0] irq_lvl,
  input  sys_lvl_t                      sys_lvl,
  output logic                          take_valid,
  output exc_t                          take_exc
);
  rank_t exec_rank, best;

  always_comb begin
    unique case (active_exc)
      EXC_THREAD: exec_rank = RANK_THREAD;
      EXC_NMI:    exec_rank = RANK_NMI;
      EXC_HF:     exec_rank = RANK_HF;
      EXC_SVC:    exec_rank = lvl_rank(sys_lvl.svc);
      EXC_DEFER:  exec_rank = lvl_rank(sys_lvl.defer);
      EXC_TICK:   exec_rank = lvl_rank(sys_lvl.tick);
      default:    exec_rank = RANK_RSVD;
    endcase
    for (int i = 0; i < NUM_IRQ; i++)
      if (active_exc == EXC_W'(IRQ_BASE + i)) exec_rank = lvl_rank(irq_lvl[i]);
    if (mask_all && exec_rank > RANK_LVL0) exec_rank = RANK_LVL0;

    // scan in ascending exception number; strict compare keeps the earlier one on ties
    best       = exec_rank;
    take_valid = 1'b0;
    take_exc   = EXC_THREAD;
    if (nmi_pend && RANK_NMI < best) begin
      best = RANK_NMI; take_valid = 1'b1; take_exc = EXC_NMI;
    end
    if (svc_pend && lvl_rank(sys_lvl.svc) < best) begin
      best = lvl_rank(sys_lvl.svc); take_valid = 1'b1; take_exc = EXC_SVC;
    end
    if (defer_pend && lvl_rank(sys_lvl.defer) < best) begin
      best = lvl_rank(sys_lvl.defer); take_valid = 1'b1; take_exc = EXC_DEFER;
    end
    if (tick_pend && lvl_rank(sys_lvl.tick) < best) begin
      best = lvl_rank(sys_lvl.tick); take_valid = 1'b1; take_exc = EXC_TICK;
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (irq_pend[i] && irq_enable[i] && lvl_rank(irq_lvl[i]) < best) begin
        best       = lvl_rank(irq_lvl[i]);
        take_valid = 1'b1;
        take_exc   = EXC_W'(IRQ_BASE + i);
      end
    end
  end
endmodule

// File: rtl/prio_preempt_arb.sv
module prio_preempt_arb
  import ppa_pkg::*;
#(
  parameter int NUM_IRQ = 26,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_pend_set,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic               nmi_req,
  input  logic               svc_req,
  input  logic               defer_req,
  input  logic               tick_req,
  input  logic [EXC_W-1:0]   active_exc,
  input  logic               mask_all,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               take_valid,
  output logic [EXC_W-1:0]   take_exc,
  input  logic               take_ack,
  output logic               wake
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NUM_IRQ-1:0][LVL_W-1:0] irq_lvl;
  sys_lvl_t                      sys_lvl;
  logic [NUM_IRQ-1:0]            irq_pend;
  logic                          nmi_pend, svc_pend, defer_pend, tick_pend;
  logic                          accept;

  assign accept = take_ack && take_valid;

  ppa_prio_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .irq_lvl(irq_lvl), .sys_lvl(sys_lvl), .rdata(cfg_rdata)
  );

  ppa_pending #(.NUM_IRQ(NUM_IRQ)) i_pend (
    .clk(clk), .rst_n(rst_sync_n), .irq_set(irq_pend_set), .nmi_set(nmi_req),
    .svc_set(svc_req), .defer_set(defer_req), .tick_set(tick_req),
    .clr_en(accept), .clr_exc(take_exc),
    .irq_pend(irq_pend), .nmi_pend(nmi_pend), .svc_pend(svc_pend),
    .defer_pend(defer_pend), .tick_pend(tick_pend)
  );

  ppa_select #(.NUM_IRQ(NUM_IRQ)) i_sel (
    .active_exc(active_exc), .mask_all(mask_all), .irq_pend(irq_pend),
    .irq_enable(irq_enable), .nmi_pend(nmi_pend), .svc_pend(svc_pend),
    .defer_pend(defer_pend), .tick_pend(tick_pend), .irq_lvl(irq_lvl),
    .sys_lvl(sys_lvl), .take_valid(take_valid), .take_exc(take_exc)
  );

  assign wake = take_valid;

  // R7: the running exception is never offered to itself
  p_no_self_preempt_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_valid |-> (take_exc != active_exc));

  // R9: under the mask only the NMI gets through
  p_mask_nmi_only_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_all && take_valid) |-> (take_exc == EXC_NMI));

  // R10: while hard fault runs, only the NMI gets through
  p_hf_nmi_only_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active_exc == EXC_HF && take_valid) |-> (take_exc == EXC_NMI));

  // R2: every offer names an implemented exception
  p_legal_exc_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_valid |-> (take_exc == EXC_NMI || take_exc == EXC_SVC || take_exc == EXC_DEFER ||
                    take_exc == EXC_TICK ||
                    (take_exc >= EXC_W'(IRQ_BASE) && take_exc < EXC_W'(IRQ_BASE + NUM_IRQ))));
endmodule

// File: tb/test_prio_preempt_arb.sv
module test_prio_preempt_arb;
  localparam int NI = 26;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] irq_pend_set, irq_enable;
  logic          nmi_req, svc_req, defer_req, tick_req;
  logic [5:0]    active_exc;
  logic          mask_all, cfg_we, take_ack;
  logic [3:0]    cfg_addr;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic          take_valid, wake;
  logic [5:0]    take_exc;

  always #4 clk = ~clk;

  prio_preempt_arb i_prio_preempt_arb (
    .clk(clk), .rst_n(rst_n), .irq_pend_set(irq_pend_set), .irq_enable(irq_enable),
    .nmi_req(nmi_req), .svc_req(svc_req), .defer_req(defer_req), .tick_req(tick_req),
    .active_exc(active_exc), .mask_all(mask_all), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .take_valid(take_valid),
    .take_exc(take_exc), .take_ack(take_ack), .wake(wake)
  );

  typedef struct {
    int          kind;   // 0 offer, 1 wake, 2 readback
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t q[$];
  event  ev;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  // monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      @ev;
      while (q.size() > 0) begin
        item_t it;
        logic  ok;
        logic [31:0] act;
        it = q.pop_front();
        checks++;
        case (it.kind)
          0: begin
            act = {25'd0, take_valid, take_exc};
            ok  = (take_valid == it.val[6]) && (!it.val[6] || take_exc == it.val[5:0]);
          end
          1: begin
            act = {31'd0, wake};
            ok  = (wake == it.val[0]);
          end
          default: begin
            act = cfg_rdata;
            ok  = (cfg_rdata == it.val);
          end
        endcase
        if (!ok) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
        end
      end
    end
  end

  task automatic exp_take(input logic v, input int exc, input string tag);
    item_t a, b;
    a.kind = 0; a.val = {25'd0, v, 6'(exc)}; a.tag = tag;
    b.kind = 1; b.val = {31'd0, v};          b.tag = {"R12 ", tag};
    q.push_back(a);
    q.push_back(b);
    ->ev;
    #1;
  endtask

  task automatic exp_rd(input int addr, input logic [31:0] v, input string tag);
    item_t a;
    @(negedge clk);
    cfg_addr = 4'(addr);
    #1;
    a.kind = 2; a.val = v; a.tag = tag;
    q.push_back(a);
    ->ev;
    #1;
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic pend_irq(input int n);
    @(negedge clk);
    irq_pend_set[n] = 1'b1;
    @(negedge clk);
    irq_pend_set[n] = 1'b0;
    #1;
  endtask

  task automatic pend_sys(input int e);
    @(negedge clk);
    case (e)
      2:       nmi_req   = 1'b1;
      11:      svc_req   = 1'b1;
      14:      defer_req = 1'b1;
      default: tick_req  = 1'b1;
    endcase
    @(negedge clk);
    nmi_req = 1'b0; svc_req = 1'b0; defer_req = 1'b0; tick_req = 1'b0;
    #1;
  endtask

  task automatic ack();
    @(negedge clk);
    take_ack = 1'b1;
    @(negedge clk);
    take_ack = 1'b0;
    #1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0;
    irq_pend_set = '0; irq_enable = '0;
    nmi_req = 1'b0; svc_req = 1'b0; defer_req = 1'b0; tick_req = 1'b0;
    active_exc = 6'd0; mask_all = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    take_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;

    // R1: reset state
    exp_take(1'b0, 0, "R1 no offer after reset");
    exp_rd(0, 32'h0, "R1 word 0");
    exp_rd(8, 32'h0, "R1 word 8");
    exp_rd(9, 32'h0, "R1 word 9");

    // R2 R6: single enabled IRQ in thread mode
    irq_enable = '1;
    pend_irq(5);
    exp_take(1'b1, 21, "R2 R6 IRQ5 offered");
    ack();
    exp_take(1'b0, 0, "R11 cleared after ack");

    // R2: disabled IRQ is not a candidate
    irq_enable[3] = 1'b0;
    pend_irq(3);
    exp_take(1'b0, 0, "R2 disabled IRQ3");
    irq_enable[3] = 1'b1;
    #1;
    exp_take(1'b1, 19, "R2 IRQ3 after enable");
    ack();

    // R3 R4 R5: register layout and masking
    wr(1, 32'hFFFF_FFFF);
    exp_rd(1, 32'hC0C0_C0C0, "R3 word 1");
    wr(6, 32'hFFFF_FFFF);
    exp_rd(6, 32'h0000_C0C0, "R3 word 6 upper bytes dropped");
    exp_rd(7, 32'h0, "R3 unmapped word");
    wr(8, 32'hFFFF_FFFF);
    exp_rd(8, 32'hC000_0000, "R4 word 8");
    wr(9, 32'hFFFF_FFFF);
    exp_rd(9, 32'hC0C0_0000, "R5 word 9");
    wr(1, 32'h0); wr(6, 32'h0); wr(8, 32'h0); wr(9, 32'h0);

    // R8: ties by exception number
    pend_irq(7);
    pend_irq(2);
    exp_take(1'b1, 18, "R8 IRQ2 before IRQ7");
    pend_sys(11);
    exp_take(1'b1, 11, "R8 svc before IRQs");
    ack();
    exp_take(1'b1, 18, "R11 other flags kept");
    wr(0, 32'h0040_0000);   // IRQ2 at level 1
    exp_take(1'b1, 23, "R3 byte 2 sets IRQ2 level");
    ack();
    exp_take(1'b1, 18, "R11 only IRQ7 cleared");
    ack();
    exp_take(1'b0, 0, "R11 all drained");
    wr(0, 32'h0);

    // R7: strict preemption with a held level source
    active_exc = 6'd20;
    @(negedge clk);
    irq_pend_set[4] = 1'b1;
    @(negedge clk);
    #1;
    exp_take(1'b0, 0, "R7 held IRQ4 vs itself");
    pend_irq(9);
    exp_take(1'b0, 0, "R7 equal level not offered");
    wr(1, 32'h0000_0080);   // IRQ4 at level 2
    exp_take(1'b1, 25, "R7 better level offered");
    ack();
    exp_take(1'b0, 0, "R7 nothing better left");
    @(negedge clk);
    irq_pend_set[4] = 1'b0;
    active_exc = 6'd0;
    #1;
    exp_take(1'b1, 20, "R6 IRQ4 in thread mode");
    ack();
    wr(1, 32'h0);

    // R9 R10: mask boost
    mask_all = 1'b1;
    pend_irq(0);
    exp_take(1'b0, 0, "R9 level 0 masked");
    pend_sys(2);
    exp_take(1'b1, 2, "R9 R10 NMI through mask");
    ack();
    exp_take(1'b0, 0, "R9 still masked");
    mask_all = 1'b0;
    #1;
    exp_take(1'b1, 16, "R9 unmask");
    ack();

    // R10: hard fault active
    active_exc = 6'd3;
    pend_sys(11);
    exp_take(1'b0, 0, "R10 svc blocked by hard fault");
    pend_sys(2);
    exp_take(1'b1, 2, "R10 NMI over hard fault");
    ack();
    active_exc = 6'd0;
    #1;
    exp_take(1'b1, 11, "R6 svc in thread mode");
    ack();

    // R11: set wins over clear
    @(negedge clk);
    irq_pend_set[1] = 1'b1;
    @(negedge clk);
    #1;
    exp_take(1'b1, 17, "R2 IRQ1");
    ack();
    exp_take(1'b1, 17, "R11 set beats clear");
    @(negedge clk);
    irq_pend_set[1] = 1'b0;
    ack();
    exp_take(1'b0, 0, "R11 IRQ1 cleared");

    // R4 R5: system levels steer selection
    wr(9, 32'h0040_0000);   // deferred level 1, tick level 0
    pend_sys(14);
    pend_sys(15);
    exp_take(1'b1, 15, "R5 tick level 0 first");
    ack();
    exp_take(1'b1, 14, "R5 deferred next");
    wr(8, 32'hC000_0000);   // svc level 3
    pend_sys(11);
    exp_take(1'b1, 14, "R4 svc level 3 loses");
    ack();
    exp_take(1'b1, 11, "R4 svc last");
    ack();
    exp_take(1'b0, 0, "R11 empty");

    done = 1'b1;
    report();
  end
endmodule